// File: doc/BRIEF.md
# Front-to-Back Ray Compositing Unit

This unit turns the stream of classified samples along one viewing ray into a single pixel. Samples arrive nearest first. Each sample carries a colour per RGB channel and a transparency value. The unit keeps a running colour and a running transparency product for the open ray. Every sample adds its colour, weighted by its own opacity and by the transparency in front of it, and the unit then scales the running transparency down. When the ray closes, the pixel colour and the residual transparency leave on a valid/ready output. The accumulators then return to their empty values.

The work is split between nodes per pixel, so the (colour, transparency) pair is the unit of exchange. A merge token carries a partial pair from a node that lies in front of the local samples. That pair is composited over whatever the local ray has gathered so far. A merge token that also opens the ray simply imports the pair. The unit takes one token per clock. A stalled output holds the whole pipeline without dropping a token.

Processing uses two register stages. Stage one registers the token and forms the opacity-weighted colour. Stage two holds a two-state ray FSM: ST_IDLE means no ray is open and ST_RAY means a ray is open. It has four named transitions. "open" goes from ST_IDLE to ST_RAY on a token without the last flag. "single" stays in ST_IDLE on a token with the last flag. "extend" stays in ST_RAY on a token without the last flag, and a first flag there restarts the ray. "close" goes from ST_RAY to ST_IDLE on a token with the last flag. An output register then presents the closed pixel.

Top module: `ray_compositor`

## Requirements
- R1: After reset, m_valid is 0, s_ready is 1, and the accumulated colour is 0 with transparency 255. A ray whose first token lacks the first flag therefore starts from those values.
- R2: Values are 8-bit unsigned fixed point, with 255 meaning 1.0. The product of a and b is round(a·b/255). For a sample token with transparency t and channel colour c, each channel becomes C + mul(mul(255−t, c), T). The channel positions are red at s_rgb[23:16], green at [15:8] and blue at [7:0], and the same positions apply on m_rgb.
- R3: Every sample or merge token with transparency t sets T to mul(t, T), where T is the transparency before the token.
- R4: A colour sum above 255 saturates at 255.
- R5: A token with s_first set discards any open partial result. It starts from colour 0 and transparency 255 before it is applied.
- R6: The result appears with m_valid two clock edges after the last-flagged token is accepted, provided the output is not stalled. The next ray starts from 0 and 255 even without a first flag.
- R7: A token with s_merge set carries a front partial pair (C_in in s_rgb, T_in in s_t). It yields C = sat(C_in + mul(T_in, C)) and T = mul(T_in, T). Combined with s_first, it loads C_in and T_in unchanged.
- R8: s_ready is 1 whenever m_valid is 0 or m_ready is 1, so an unstalled unit accepts one token per clock.
- R9: While m_valid is 1 and m_ready is 0, s_ready is 0 and m_rgb and m_t stay unchanged. No accepted token is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Token valid |
| s_ready | output | 1 | Token accepted when high with s_valid |
| s_first | input | 1 | Token opens a new ray |
| s_last | input | 1 | Token closes the ray |
| s_merge | input | 1 | Token is a front partial pair, not a sample |
| s_rgb | input | 24 | Sample colour or partial colour, R/G/B from high to low byte |
| s_t | input | 8 | Sample transparency or partial transparency |
| m_valid | output | 1 | Pixel result valid |
| m_ready | input | 1 | Downstream accepts the pixel |
| m_rgb | output | 24 | Composited pixel colour |
| m_t | output | 8 | Residual transparency of the ray |

## Verification
Two functions can fall in the same clock edge. The output register may hand off a finished pixel while stage two closes the next ray into that same register. A held pixel may also meet a ray end waiting in stage one. Both cases are provoked by back-to-back single-token rays driven against a random m_ready and random input gaps. Results are judged by popping an arithmetically computed expected queue in order and by confirming that a held pixel keeps its value while s_ready stays low.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int CW  = 8;
    localparam int NCH = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RAY  = 1'b1
    } ray_state_e;
endpackage

// File: rtl/rc_fxmul.sv
module rc_fxmul #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] HALF = PW'(1) << (W - 1);

    logic [PW-1:0] prod;
    logic [PW-1:0] biased;
    logic [PW-1:0] folded;

    // round(a*b / (2^W - 1)) without a divider
    always_comb begin
        prod   = PW'(a) * PW'(b);
        biased = prod + HALF;
        folded = biased + (biased >> W);
        y      = folded[PW-1:W];
    end
endmodule

// File: rtl/rc_front.sv
module rc_front #(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           in_valid,
    input  logic           in_first,
    input  logic           in_last,
    input  logic           in_merge,
    input  logic [N*W-1:0] in_col,
    input  logic [W-1:0]   in_t,
    output logic           s1_v,
    output logic           s1_first,
    output logic           s1_last,
    output logic           s1_merge,
    output logic [N*W-1:0] s1_w,
    output logic [W-1:0]   s1_t
);
    localparam logic [W-1:0] ONE = '1;

    logic [W-1:0]   opac;
    logic [N*W-1:0] wgt;
    logic [N*W-1:0] pick;

    assign opac = ONE - in_t;

    for (genvar ch = 0; ch < N; ch++) begin : g_wgt
        rc_fxmul #(.W(W)) u_mul (
            .a (opac),
            .b (in_col[ch*W +: W]),
            .y (wgt[ch*W +: W])
        );
    end

    // a partial pair passes through untouched
    assign pick = in_merge ? in_col : wgt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_merge <= 1'b0;
            s1_w     <= '0;
            s1_t     <= '0;
        end else if (adv) begin
            s1_v <= in_valid;
            if (in_valid) begin
                s1_first <= in_first;
                s1_last  <= in_last;
                s1_merge <= in_merge;
                s1_w     <= pick;
                s1_t     <= in_t;
            end
        end
    end
endmodule

// File: rtl/rc_accum.sv
module rc_accum
    import rc_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic           s1_first,
    input  logic           s1_last,
    input  logic           s1_merge,
    input  logic [N*W-1:0] s1_w,
    input  logic [W-1:0]   s1_t,
    output logic [N*W-1:0] acc_c,
    output logic [W-1:0]   acc_t,
    output logic [N*W-1:0] nxt_c,
    output logic [W-1:0]   nxt_t
);
    localparam logic [W-1:0] ONE = '1;

    ray_state_e     state_q;
    ray_state_e     state_d;
    logic           fresh;
    logic [N*W-1:0] base_c;
    logic [W-1:0]   base_t;

    assign fresh  = (state_q == ST_IDLE) || s1_first;
    assign base_c = fresh ? '0 : acc_c;
    assign base_t = fresh ? ONE : acc_t;

    for (genvar ch = 0; ch < N; ch++) begin : g_chan
        logic [W-1:0] ma;
        logic [W-1:0] mb;
        logic [W-1:0] addend;
        logic [W-1:0] prod;
        logic [W:0]   sum;

        assign ma     = s1_merge ? s1_t : s1_w[ch*W +: W];
        assign mb     = s1_merge ? base_c[ch*W +: W] : base_t;
        assign addend = s1_merge ? s1_w[ch*W +: W] : base_c[ch*W +: W];

        rc_fxmul #(.W(W)) u_mul (
            .a (ma),
            .b (mb),
            .y (prod)
        );

        assign sum = {1'b0, addend} + {1'b0, prod};
        assign nxt_c[ch*W +: W] = sum[W] ? ONE : sum[W-1:0];
    end

    rc_fxmul #(.W(W)) u_tmul (
        .a (s1_t),
        .b (base_t),
        .y (nxt_t)
    );

    // transitions: open, single, extend, close
    always_comb begin
        state_d = state_q;
        if (fire) begin
            unique case (state_q)
                ST_IDLE: state_d = s1_last ? ST_IDLE : ST_RAY;
                ST_RAY:  state_d = s1_last ? ST_IDLE : ST_RAY;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_c <= '0;
            acc_t <= ONE;
        end else if (fire) begin
            if (s1_last) begin
                acc_c <= '0;
                acc_t <= ONE;
            end else begin
                acc_c <= nxt_c;
                acc_t <= nxt_t;
            end
        end
    end
endmodule

// File: rtl/rc_outreg.sv
module rc_outreg #(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic           load,
    input  logic [N*W-1:0] d_col,
    input  logic [W-1:0]   d_t,
    output logic           q_valid,
    output logic [N*W-1:0] q_col,
    output logic [W-1:0]   q_t
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_col   <= '0;
            q_t     <= '0;
        end else if (adv) begin
            q_valid <= load;
            if (load) begin
                q_col <= d_col;
                q_t   <= d_t;
            end
        end
    end
endmodule

// File: rtl/ray_compositor.sv
module ray_compositor #(
    parameter int W = rc_pkg::CW,
    parameter int N = rc_pkg::NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_valid,
    output logic           s_ready,
    input  logic           s_first,
    input  logic           s_last,
    input  logic           s_merge,
    input  logic [N*W-1:0] s_rgb,
    input  logic [W-1:0]   s_t,
    output logic           m_valid,
    input  logic           m_ready,
    output logic [N*W-1:0] m_rgb,
    output logic [W-1:0]   m_t
);
    logic           adv;
    logic           fire;
    logic           s1_v;
    logic           s1_first;
    logic           s1_last;
    logic           s1_merge;
    logic [N*W-1:0] s1_w;
    logic [W-1:0]   s1_t;
    logic [N*W-1:0] acc_c;
    logic [W-1:0]   acc_t;
    logic [N*W-1:0] nxt_c;
    logic [W-1:0]   nxt_t;

    assign adv     = !m_valid || m_ready;
    assign s_ready = adv;
    assign fire    = adv && s1_v;

    rc_front #(.W(W), .N(N)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .in_valid (s_valid),
        .in_first (s_first),
        .in_last  (s_last),
        .in_merge (s_merge),
        .in_col   (s_rgb),
        .in_t     (s_t),
        .s1_v     (s1_v),
        .s1_first (s1_first),
        .s1_last  (s1_last),
        .s1_merge (s1_merge),
        .s1_w     (s1_w),
        .s1_t     (s1_t)
    );

    rc_accum #(.W(W), .N(N)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .s1_first (s1_first),
        .s1_last  (s1_last),
        .s1_merge (s1_merge),
        .s1_w     (s1_w),
        .s1_t     (s1_t),
        .acc_c    (acc_c),
        .acc_t    (acc_t),
        .nxt_c    (nxt_c),
        .nxt_t    (nxt_t)
    );

    rc_outreg #(.W(W), .N(N)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .load    (fire && s1_last),
        .d_col   (nxt_c),
        .d_t     (nxt_t),
        .q_valid (m_valid),
        .q_col   (m_rgb),
        .q_t     (m_t)
    );
endmodule

// File: rtl/rc_chk.sv
module rc_chk #(
    parameter int W = 8,
    parameter int N = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           s_ready,
    input logic           m_valid,
    input logic           m_ready,
    input logic [N*W-1:0] m_rgb,
    input logic [W-1:0]   m_t,
    input logic           adv,
    input logic           s1_v,
    input logic           s1_last,
    input logic [N*W-1:0] acc_c,
    input logic [W-1:0]   acc_t
);
    // R8
    accept_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_valid || m_ready) |-> s_ready);

    // R9
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |-> !s_ready);

    // R9
    held_pixel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_rgb) && $stable(m_t)));

    // R6
    result_follows_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_v && s1_last) |=> m_valid);

    // R6
    accum_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_v && s1_last) |=> ((acc_c == '0) && (&acc_t)));
endmodule

bind ray_compositor rc_chk #(.W(W), .N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_rgb   (m_rgb),
    .m_t     (m_t),
    .adv     (adv),
    .s1_v    (s1_v),
    .s1_last (s1_last),
    .acc_c   (acc_c),
    .acc_t   (acc_t)
);

// File: tb/tb_ray_compositor.sv
module tb_ray_compositor;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        s_first = 1'b0;
    logic        s_last = 1'b0;
    logic        s_merge = 1'b0;
    logic [23:0] s_rgb = '0;
    logic [7:0]  s_t = '0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [23:0] m_rgb;
    logic [7:0]  m_t;

    int errors = 0;
    int checks = 0;
    int stepn = 0;
    int rmode = 0;
    int vmode = 0;
    bit latchk = 1'b0;
    bit done = 1'b0;

    logic [34:0] tok_q[$];
    logic [31:0] exp_q[$];
    int          lq[$];

    int  mc[3];
    int  mt;
    bit  mopen = 1'b0;

    bit          prev_stall = 1'b0;
    logic [23:0] prev_rgb;
    logic [7:0]  prev_t;

    always #(CLK_PERIOD/2) clk = ~clk;

    ray_compositor dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_first(s_first), .s_last(s_last), .s_merge(s_merge),
        .s_rgb(s_rgb), .s_t(s_t), .m_valid(m_valid), .m_ready(m_ready),
        .m_rgb(m_rgb), .m_t(m_t)
    );

    function automatic int fm(int a, int b);
        return (2 * a * b + 255) / 510;
    endfunction

    function automatic int sat(int v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model of R2..R7, applied when the token is queued
    task automatic push(bit f, bit l, bit mg, logic [23:0] rgb, logic [7:0] t);
        if (f || !mopen) begin
            for (int ch = 0; ch < 3; ch++) mc[ch] = 0;
            mt = 255;
        end
        for (int ch = 0; ch < 3; ch++) begin
            int c = int'(rgb[ch*8 +: 8]);
            if (mg) mc[ch] = sat(c + fm(int'(t), mc[ch]));
            else    mc[ch] = sat(mc[ch] + fm(fm(255 - int'(t), c), mt));
        end
        mt = fm(int'(t), mt);
        tok_q.push_back({f, l, mg, rgb, t});
        if (l) begin
            exp_q.push_back({8'(mc[2]), 8'(mc[1]), 8'(mc[0]), 8'(mt)});
            mopen = 1'b0;
        end else begin
            mopen = 1'b1;
        end
    endtask

    task automatic step();
        m_ready = (rmode == 0) ? 1'b1 : ($urandom_range(0, 1) == 1);
        if (tok_q.size() > 0 && (vmode == 0 || $urandom_range(0, 3) != 0)) begin
            s_valid = 1'b1;
            {s_first, s_last, s_merge, s_rgb, s_t} = tok_q[0];
        end else begin
            s_valid = 1'b0;
            {s_first, s_last, s_merge, s_rgb, s_t} = '0;
        end
        #1;
        if (prev_stall) begin
            // R9: held pixel unchanged
            chk(m_valid && m_rgb == prev_rgb && m_t == prev_t, "R9 hold",
                {m_valid, m_rgb, m_t}, {1'b1, prev_rgb, prev_t});
        end
        if (m_valid && !m_ready) begin
            // R9: input blocked during stall
            chk(!s_ready, "R9 stall", s_ready, 0);
        end else begin
            // R8: accept whenever not stalled
            chk(s_ready, "R8 ready", s_ready, 1);
        end
        if (s_valid && s_ready) begin
            if (s_last) lq.push_back(stepn);
            void'(tok_q.pop_front());
        end
        if (m_valid && m_ready) begin
            logic [31:0] e;
            int a;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 extra pixel", {m_rgb, m_t}, 0);
            end else begin
                e = exp_q.pop_front();
                a = lq.pop_front();
                // R2 R3 R4 R5 R7 pixel value
                chk({m_rgb, m_t} == e, "R2/R3 pixel", {m_rgb, m_t}, e);
                if (latchk) begin
                    // R6 latency of two edges
                    chk(stepn - a == 2, "R6 latency", stepn - a, 2);
                end
            end
        end
        prev_stall = m_valid && !m_ready;
        prev_rgb = m_rgb;
        prev_t = m_t;
        stepn++;
        @(negedge clk);
    endtask

    task automatic drain();
        while (tok_q.size() > 0 || exp_q.size() > 0) step();
        for (int i = 0; i < 3; i++) step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!m_valid, "R1 m_valid", m_valid, 0);
        chk(s_ready, "R1 s_ready", s_ready, 1);
        @(negedge clk);

        // R1 ray without first flag straight after reset
        push(1'b0, 1'b1, 1'b0, 24'h804020, 8'd100);
        rmode = 0; vmode = 0; latchk = 1'b1;
        drain();

        // R2 R3 single-token sweep over transparency and colour
        for (int t = 0; t < 256; t += 17)
            for (int c = 0; c < 256; c += 15)
                push(1'b1, 1'b1, 1'b0, {8'(c), 8'(255 - c), 8'(c) ^ 8'h5A}, 8'(t));
        drain();

        // R2 R3 two-sample sweep: second sample seen through the first
        for (int a = 0; a < 256; a += 51)
            for (int b = 0; b < 256; b += 51) begin
                push(1'b1, 1'b0, 1'b0, 24'h10F080, 8'(a));
                push(1'b0, 1'b1, 1'b0, 24'hC8C8C8, 8'(b));
            end
        drain();

        // R4 saturation through a merge onto a bright local ray
        push(1'b1, 1'b0, 1'b0, 24'hC8C8C8, 8'd0);
        push(1'b0, 1'b1, 1'b1, 24'hFAFA10, 8'd255);
        // R7 import by first+merge
        push(1'b1, 1'b1, 1'b1, 24'h123456, 8'd77);
        // R7 merge with partial transparency
        push(1'b1, 1'b0, 1'b0, 24'h90A0B0, 8'd60);
        push(1'b0, 1'b0, 1'b0, 24'h203040, 8'd200);
        push(1'b0, 1'b1, 1'b1, 24'h080808, 8'd128);
        // R5 restart mid-ray discards the partial result
        push(1'b1, 1'b0, 1'b0, 24'hFFFFFF, 8'd0);
        push(1'b1, 1'b1, 1'b0, 24'h405060, 8'd30);
        // R6 next ray without first after a close
        push(1'b0, 1'b0, 1'b0, 24'h112233, 8'd240);
        push(1'b0, 1'b1, 1'b0, 24'h445566, 8'd10);
        drain();

        // R9 random backpressure and gaps, mixed ray shapes
        rmode = 1; vmode = 1; latchk = 1'b0;
        for (int r = 0; r < 120; r++) begin
            int len = $urandom_range(1, 5);
            for (int k = 0; k < len; k++) begin
                bit f = (k == 0) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 9) == 0);
                bit l = (k == len - 1);
                bit mg = l ? ($urandom_range(0, 2) == 0) : 1'b0;
                push(f, l, mg, 24'($urandom), 8'($urandom));
            end
        end
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", tok_q.size() + exp_q.size(), 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule